// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard logic of a five-stage integer pipeline with fetch, decode, execute, memory and write-back stages separated by four pipeline registers. It compares register numbers across the stages and produces three kinds of result in the same cycle:

- operand selects that steer each ALU input to the register file value, the execute-to-memory result, or the memory-to-writeback result;
- decode-stage bypass flags that let a register read in decode see a value being written back in that same cycle;
- hold and bubble controls that freeze the program counter and the fetch/decode register, and empty one of the pipeline registers.

Two stalls are produced. A load-use stall is raised when the instruction in decode needs the value a load in execute will return. That value exists only after the memory stage, so it cannot be forwarded in time. A structural stall is raised when a build parameter selects one shared memory for instructions and data and the memory stage is using it. In that case the fetch is dropped and the older instructions keep moving. Branch handling and the datapath itself lie outside the block, and every output is a pure function of the present inputs.

Top module: `pipe_hazard_unit`

## Requirements
- R1: An ALU operand select is 2'b10 (take the execute-to-memory result) when that stage writes a nonzero register equal to the operand's source number in execute.
- R2: An ALU operand select is 2'b01 (take the memory-to-writeback result) when that stage writes a nonzero register equal to the source number and R1 does not apply; when both stages match, 2'b10 wins.
- R3: An ALU operand select is 2'b00 (register file) when neither stage matches, when the matching stage does not write, or when the source number is 0.
- R4: A decode bypass flag is 1 when the writeback stage writes a nonzero register equal to that decode source number, and 0 otherwise, including for register 0.
- R5: When a load in execute targets a nonzero register that equals a decode source marked as used, `pc_hold`, `ifid_hold` and `idex_bubble` are 1 and `ifid_bubble` is 0.
- R6: A decode source that is marked unused, or a load whose target is register 0, never raises a stall.
- R7: With the shared memory option set (UNIFIED_MEM=1), a load or store in the memory stage with no load-use hazard gives `pc_hold`=1 and `ifid_bubble`=1, with `ifid_hold`=0 and `idex_bubble`=0, so the decode instruction still advances.
- R8: When a load-use hazard and a shared-memory collision occur together, the load-use outputs of R5 apply and `ifid_bubble` is 0.
- R9: With separate memories (UNIFIED_MEM=0), memory-stage loads and stores never raise any hold or bubble.
- R10: With no hazard present, all four hold and bubble outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RW | First source register number in decode |
| id_rs2 | input | RW | Second source register number in decode |
| id_rs1_used | input | 1 | Decode instruction reads its first source |
| id_rs2_used | input | 1 | Decode instruction reads its second source |
| ex_rs1 | input | RW | First source register number in execute |
| ex_rs2 | input | RW | Second source register number in execute |
| ex_rd | input | RW | Destination register of the execute instruction |
| ex_load | input | 1 | Execute instruction is a load |
| exmem_rd | input | RW | Destination held in the execute-to-memory register |
| exmem_we | input | 1 | Register write enable in the execute-to-memory register |
| mem_load | input | 1 | Memory-stage instruction reads data memory |
| mem_store | input | 1 | Memory-stage instruction writes data memory |
| memwb_rd | input | RW | Destination held in the memory-to-writeback register |
| memwb_we | input | 1 | Register write enable in the memory-to-writeback register |
| fwd_a | output | 2 | First ALU operand select (00 file, 10 exec-mem, 01 mem-wb) |
| fwd_b | output | 2 | Second ALU operand select, same encoding |
| id_wb_a | output | 1 | First decode read takes the writeback value |
| id_wb_b | output | 1 | Second decode read takes the writeback value |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| ifid_bubble | output | 1 | Load a no-op into the fetch/decode register |
| idex_bubble | output | 1 | Clear the control bits of the decode/execute register |

## Verification
Every result is combinational, so each one is due in the same cycle as the stimulus that causes it and no register lies between inputs and outputs. Each directed task sets a complete input pattern at a falling clock edge and samples all outputs one nanosecond later. This is well before the next rising edge, so no sample can catch a half-applied pattern. A second instance built with separate memories receives the same memory-stage stimulus, which shows that the structural stall comes from the parameter alone.

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit #(
  parameter int RW          = 5,
  parameter bit UNIFIED_MEM = 1'b1
) (
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_rs1_used,
  input  logic          id_rs2_used,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_load,
  input  logic [RW-1:0] exmem_rd,
  input  logic          exmem_we,
  input  logic          mem_load,
  input  logic          mem_store,
  input  logic [RW-1:0] memwb_rd,
  input  logic          memwb_we,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          id_wb_a,
  output logic          id_wb_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          ifid_bubble,
  output logic          idex_bubble
);

  localparam logic [RW-1:0] ZERO = '0;
  localparam logic [1:0] SEL_FILE  = 2'b00;
  localparam logic [1:0] SEL_EXMEM = 2'b10;
  localparam logic [1:0] SEL_MEMWB = 2'b01;

  logic exmem_live, memwb_live, load_live;
  logic mem_busy, load_use;

  assign exmem_live = exmem_we && (exmem_rd != ZERO);
  assign memwb_live = memwb_we && (memwb_rd != ZERO);
  assign load_live  = ex_load  && (ex_rd    != ZERO);

  function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                      input logic e_live, input logic [RW-1:0] e_rd,
                                      input logic w_live, input logic [RW-1:0] w_rd);
    if (e_live && e_rd == src)      return SEL_EXMEM;
    else if (w_live && w_rd == src) return SEL_MEMWB;
    else                            return SEL_FILE;
  endfunction

  assign fwd_a = pick(ex_rs1, exmem_live, exmem_rd, memwb_live, memwb_rd);
  assign fwd_b = pick(ex_rs2, exmem_live, exmem_rd, memwb_live, memwb_rd);

  assign id_wb_a = memwb_live && (memwb_rd == id_rs1);
  assign id_wb_b = memwb_live && (memwb_rd == id_rs2);

  assign load_use = load_live &&
                    ((id_rs1_used && ex_rd == id_rs1) ||
                     (id_rs2_used && ex_rd == id_rs2));

  generate
    if (UNIFIED_MEM) begin : g_shared
      assign mem_busy = mem_load || mem_store;
    end else begin : g_split
      logic unused_mem;
      assign unused_mem = mem_load ^ mem_store;
      assign mem_busy = 1'b0;
    end
  endgenerate

  assign pc_hold     = load_use || mem_busy;
  assign ifid_hold   = load_use;
  assign ifid_bubble = mem_busy && !load_use;
  assign idex_bubble = load_use;

endmodule

// File: rtl/pipe_hazard_unit_chk.sv
module pipe_hazard_unit_chk #(
  parameter int RW          = 5,
  parameter bit UNIFIED_MEM = 1'b1
) (
  input logic [RW-1:0] id_rs1,
  input logic [RW-1:0] ex_rs1,
  input logic [RW-1:0] ex_rs2,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic          id_wb_a,
  input logic          pc_hold,
  input logic          ifid_hold,
  input logic          ifid_bubble,
  input logic          idex_bubble
);
  logic known;
  assign known = !$isunknown({id_rs1, ex_rs1, ex_rs2, fwd_a, fwd_b, id_wb_a,
                              pc_hold, ifid_hold, ifid_bubble, idex_bubble});

  always_comb begin
    if (known) begin
      AST_FWD_SINGLE_SOURCE: assert ($onehot0(fwd_a) && $onehot0(fwd_b)); // R2
      AST_ZERO_NOT_FORWARDED: assert (ex_rs1 != '0 || fwd_a == 2'b00); // R3
      AST_ZERO_NO_BYPASS: assert (id_rs1 != '0 || !id_wb_a); // R4
      AST_LOADUSE_FREEZE: assert (!ifid_hold || (pc_hold && idex_bubble)); // R5
      AST_HOLD_OR_FLUSH: assert (!(ifid_hold && ifid_bubble)); // R8
      AST_FLUSH_HOLDS_PC: assert (!ifid_bubble || pc_hold); // R7
      AST_SPLIT_NO_FLUSH: assert (UNIFIED_MEM || !ifid_bubble); // R9
    end
  end
endmodule

bind pipe_hazard_unit pipe_hazard_unit_chk #(.RW(RW), .UNIFIED_MEM(UNIFIED_MEM)) u_chk (
  .id_rs1(id_rs1), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2),
  .fwd_a(fwd_a), .fwd_b(fwd_b), .id_wb_a(id_wb_a),
  .pc_hold(pc_hold), .ifid_hold(ifid_hold),
  .ifid_bubble(ifid_bubble), .idex_bubble(idex_bubble)
);

// File: tb/tb_pipe_hazard_unit.sv
module tb_pipe_hazard_unit;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exmem_rd, memwb_rd;
  logic id_rs1_used, id_rs2_used, ex_load, exmem_we, mem_load, mem_store, memwb_we;
  logic [1:0] fa, fb, sfa, sfb;
  logic wa, wb, ph, ih, ib, eb, swa, swb, sph, sih, sib, seb;

  pipe_hazard_unit #(.RW(5), .UNIFIED_MEM(1'b1)) dut (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_load(ex_load),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .mem_load(mem_load), .mem_store(mem_store),
    .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .fwd_a(fa), .fwd_b(fb), .id_wb_a(wa), .id_wb_b(wb),
    .pc_hold(ph), .ifid_hold(ih), .ifid_bubble(ib), .idex_bubble(eb));

  pipe_hazard_unit #(.RW(5), .UNIFIED_MEM(1'b0)) dut_split (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_load(ex_load),
    .exmem_rd(exmem_rd), .exmem_we(exmem_we), .mem_load(mem_load), .mem_store(mem_store),
    .memwb_rd(memwb_rd), .memwb_we(memwb_we),
    .fwd_a(sfa), .fwd_b(sfb), .id_wb_a(swa), .id_wb_b(swb),
    .pc_hold(sph), .ifid_hold(sih), .ifid_bubble(sib), .idex_bubble(seb));

  // packed view: [9:8] fwd_a, [7:6] fwd_b, 5 id_wb_a, 4 id_wb_b,
  // 3 pc_hold, 2 ifid_hold, 1 ifid_bubble, 0 idex_bubble
  wire [9:0] outs  = {fa, fb, wa, wb, ph, ih, ib, eb};
  wire [9:0] souts = {sfa, sfb, swa, swb, sph, sih, sib, seb};

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic clr();
    @(negedge clk);
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, exmem_rd, memwb_rd} = '0;
    {id_rs1_used, id_rs2_used, ex_load, exmem_we, mem_load, mem_store, memwb_we} = '0;
  endtask

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_idle();
    clr(); #1;
    chk("R10 idle", outs, 10'b00_00_0_0_0000);
  endtask

  task automatic t_fwd_exmem();
    clr(); exmem_we = 1; exmem_rd = 7; ex_rs1 = 7; ex_rs2 = 3; #1;
    chk("R1 exmem to a", outs, 10'b10_00_0_0_0000);
  endtask

  task automatic t_fwd_memwb();
    clr(); memwb_we = 1; memwb_rd = 3; ex_rs1 = 6; ex_rs2 = 3; #1;
    chk("R2 memwb to b", outs, 10'b00_01_0_0_0000);
  endtask

  task automatic t_fwd_prio();
    clr(); exmem_we = 1; exmem_rd = 5; memwb_we = 1; memwb_rd = 5;
    ex_rs1 = 5; ex_rs2 = 5; #1;
    chk("R2 exmem priority", outs, 10'b10_10_0_0_0000);
    memwb_rd = 8; ex_rs2 = 8; #1;
    chk("R1 R2 split sources", outs, 10'b10_01_0_0_0000);
  endtask

  task automatic t_no_write();
    clr(); exmem_rd = 5; memwb_rd = 5; ex_rs1 = 5; ex_rs2 = 5; #1;
    chk("R3 write disabled", outs, 10'b00_00_0_0_0000);
  endtask

  task automatic t_reg_zero();
    clr(); exmem_we = 1; memwb_we = 1; #1;
    chk("R3 R4 register zero", outs, 10'b00_00_0_0_0000);
  endtask

  task automatic t_id_bypass();
    clr(); memwb_we = 1; memwb_rd = 9; id_rs1 = 9; id_rs2 = 9; #1;
    chk("R4 wb read both", outs, 10'b00_00_1_1_0000);
    id_rs2 = 10; #1;
    chk("R4 wb read a only", outs, 10'b00_00_1_0_0000);
  endtask

  task automatic t_load_use();
    clr(); ex_load = 1; ex_rd = 4; id_rs2 = 4; id_rs2_used = 1; id_rs1 = 2; id_rs1_used = 1; #1;
    chk("R5 load use", outs, 10'b00_00_0_0_1101);
  endtask

  task automatic t_no_stall();
    clr(); ex_load = 1; ex_rd = 4; id_rs2 = 4; id_rs2_used = 0; #1;
    chk("R6 unused source", outs, 10'b00_00_0_0_0000);
    ex_rd = 0; id_rs1 = 0; id_rs1_used = 1; #1;
    chk("R6 load to zero", outs, 10'b00_00_0_0_0000);
  endtask

  task automatic t_struct();
    clr(); mem_load = 1; #1;
    chk("R7 shared load", outs, 10'b00_00_0_0_1010);
    chk("R9 split load", souts, 10'b00_00_0_0_0000);
    clr(); mem_store = 1; #1;
    chk("R7 shared store", outs, 10'b00_00_0_0_1010);
    chk("R9 split store", souts, 10'b00_00_0_0_0000);
  endtask

  task automatic t_both();
    clr(); mem_store = 1; ex_load = 1; ex_rd = 12; id_rs1 = 12; id_rs1_used = 1; #1;
    chk("R8 loaduse over struct", outs, 10'b00_00_0_0_1101);
    chk("R5 split loaduse", souts, 10'b00_00_0_0_1101);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_fwd_exmem();
    t_fwd_memwb();
    t_fwd_prio();
    t_no_write();
    t_reg_zero();
    t_id_bypass();
    t_load_use();
    t_no_stall();
    t_struct();
    t_both();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule